// File: doc/BRIEF.md
# Hitmask TDC Readout Frame Packer

The block builds the readout frame of one trigger for a 32-channel drift-time TDC and streams it one byte per clock cycle. With a trigger it receives a 32-bit header word, one 32-bit hit mask for each of up to three bunch crossings, and a 6-bit drift time for every channel of every crossing. It sends the header first, then the hit masks of the configured number of crossings, then the drift times of the channels that registered a hit. The drift times are packed back to back, with no gaps at byte boundaries.

Each frame gets a fixed slot of 36 clock cycles, which is 900 ns at 40 MHz. A frame that would need more bytes than that is cut at the 36th byte. Only drift times can be lost when this happens, because the header and the hit masks together never use more than 16 bytes. The block accepts a new trigger only when the previous slot has fully elapsed. A trigger that arrives too early is dropped and latches a violation flag, so every TDC that reads out in parallel keeps the same slot timing.

Top module: `tdc_frame_packer`

## Requirements
- R1: An accepted trigger starts a frame in the next clock cycle. The first four bytes carry the header, least significant byte first, so byte 0 is `trig_hdr[7:0]`.
- R2: `cfg_bx` sets the number of crossings N, which is sampled with the trigger. A value of 0 counts as 1. After the header come N hit masks of four bytes each, crossing 0 first and least significant byte first. Masks of crossings at or above N do not affect the frame.
- R3: After the masks, the drift time of every set mask bit is appended. The scan runs from crossing 0 bit 0 up to the highest bit of crossing N-1. Channel g of the drift input is `trig_times[6g+5:6g]`, with g = 32·crossing + bit. The times form a bit stream, least significant bit first, and stream bit 8m+k is bit k of drift byte m. Unused bits of the final byte are zero.
- R4: A frame never has more than 36 bytes. If the drift bytes would run past that, the 36th byte is the last one.
- R5: The header and all N hit masks are always sent complete, including in truncated frames.
- R6: `out_valid` stays high in every cycle from the first byte to the final byte. `out_last` is high exactly on the final byte.
- R7: The block accepts a trigger only if at least 36 cycles have passed since the previous accepted trigger. An earlier trigger produces no output and leaves the frame in progress unchanged. It sets `spacing_err`, which stays set until reset.
- R8: A frame with no set mask bit ends on the last byte of the last hit mask.
- R9: After reset, `out_valid` and `spacing_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bx | input | 2 | Number of crossings per trigger (0 counts as 1) |
| trig_valid | input | 1 | Trigger strobe; the other trigger inputs are sampled with it |
| trig_hdr | input | 32 | Header word |
| trig_masks | input | 96 | Hit masks, crossing c at bits 32c+31:32c |
| trig_times | input | 576 | Drift times, channel g at bits 6g+5:6g |
| out_valid | output | 1 | Output byte is valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the frame |
| spacing_err | output | 1 | Sticky flag for a trigger that arrived too early |

## Verification
The first header byte appears in the cycle after the clock edge that accepts the trigger. After that, one byte follows every cycle until `out_last`, so frame byte k is due k+1 cycles after acceptance. A frame triggered exactly 36 cycles after the previous one follows on from that frame's last byte without a gap. `spacing_err` rises in the cycle after the early trigger's edge. The bench computes each frame's bytes from the requirements and queues them before it raises the trigger. A monitor compares one queued byte at every falling edge where `out_valid` is high, so any extra, missing or shifted byte is reported at the cycle where it happens.

// File: rtl/tfp_pkg.sv
package tfp_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      SEG_HDR   = 2'd0,
      SEG_MASK  = 2'd1,
      SEG_DRIFT = 2'd2
   } seg_e;
endpackage

// File: rtl/tfp_slot_timer.sv
module tfp_slot_timer #(
   parameter int SLOT_CYC = 36
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic accept,
   output logic viol_flag
);
   localparam int CW = $clog2(SLOT_CYC);

   logic [CW-1:0] left_q;
   logic          viol_q;

   assign accept    = trig && (left_q == '0);
   assign viol_flag = viol_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
         viol_q <= 1'b0;
      end else begin
         if (accept)
            left_q <= CW'(SLOT_CYC - 1);
         else if (left_q != '0)
            left_q <= left_q - 1'b1;
         if (trig && (left_q != '0))
            viol_q <= 1'b1;
      end
   end
endmodule

// File: rtl/tfp_hit_scan.sv
module tfp_hit_scan #(
   parameter int NTOT = 96,
   parameter int DT_W = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [NTOT-1:0]      load_mask,
   input  logic [NTOT*DT_W-1:0] load_times,
   input  logic [1:0]           take,
   output logic [DT_W-1:0]      d1,
   output logic [DT_W-1:0]      d2,
   output logic [1:0]           avail,
   output logic                 empty
);
   localparam int IDX_W = $clog2(NTOT);

   logic [NTOT-1:0]      rem_q, rem_b, rem_n;
   logic [NTOT*DT_W-1:0] times_q;
   logic [IDX_W-1:0]     i1, i2;
   logic                 f1, f2;

   // lowest set bit of the remaining mask
   always_comb begin
      i1 = '0;
      f1 = 1'b0;
      for (int i = NTOT - 1; i >= 0; i--) begin
         if (rem_q[i]) begin
            i1 = IDX_W'(i);
            f1 = 1'b1;
         end
      end
   end

   // second lowest: same search with the first one removed
   always_comb begin
      rem_b = rem_q;
      if (f1)
         rem_b[i1] = 1'b0;
      i2 = '0;
      f2 = 1'b0;
      for (int i = NTOT - 1; i >= 0; i--) begin
         if (rem_b[i]) begin
            i2 = IDX_W'(i);
            f2 = 1'b1;
         end
      end
   end

   assign d1    = times_q[int'(i1)*DT_W +: DT_W];
   assign d2    = times_q[int'(i2)*DT_W +: DT_W];
   assign avail = {1'b0, f1} + {1'b0, f2};
   assign empty = !f1;

   always_comb begin
      rem_n = rem_q;
      if (take != 2'd0)
         rem_n[i1] = 1'b0;
      if (take == 2'd2)
         rem_n[i2] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q   <= '0;
         times_q <= '0;
      end else if (load) begin
         rem_q   <= load_mask;
         times_q <= load_times;
      end else begin
         rem_q   <= rem_n;
      end
   end
endmodule

// File: rtl/tfp_bit_packer.sv
module tfp_bit_packer
   import tfp_pkg::*;
#(
   parameter int DT_W  = 6,
   parameter int ACC_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              en,
   input  logic              emit,
   input  logic [1:0]        avail,
   input  logic [DT_W-1:0]   d1,
   input  logic [DT_W-1:0]   d2,
   output logic [1:0]        take,
   output logic [BYTE_W-1:0] byte_o,
   output logic [$clog2(ACC_W+1)-1:0] cnt_o
);
   localparam int CNT_W = $clog2(ACC_W + 1);

   logic [ACC_W-1:0] acc_q, acc_a, acc_n, ext1, ext2;
   logic [CNT_W-1:0] cnt_q, cnt_a, cnt_n;

   assign ext1   = {{(ACC_W-DT_W){1'b0}}, d1};
   assign ext2   = {{(ACC_W-DT_W){1'b0}}, d2};
   assign byte_o = acc_q[BYTE_W-1:0];
   assign cnt_o  = cnt_q;

   always_comb begin
      if (emit) begin
         acc_a = acc_q >> BYTE_W;
         cnt_a = (cnt_q > CNT_W'(BYTE_W)) ? cnt_q - CNT_W'(BYTE_W) : '0;
      end else begin
         acc_a = acc_q;
         cnt_a = cnt_q;
      end

      if (!en)
         take = 2'd0;
      else if (cnt_a <= CNT_W'(ACC_W - 2*DT_W))
         take = avail;
      else if (cnt_a <= CNT_W'(ACC_W - DT_W))
         take = (avail != 2'd0) ? 2'd1 : 2'd0;
      else
         take = 2'd0;

      acc_n = acc_a;
      cnt_n = cnt_a;
      if (take != 2'd0) begin
         acc_n = acc_n | (ext1 << cnt_a);
         cnt_n = cnt_n + CNT_W'(DT_W);
      end
      if (take == 2'd2) begin
         acc_n = acc_n | (ext2 << (cnt_a + CNT_W'(DT_W)));
         cnt_n = cnt_n + CNT_W'(DT_W);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         cnt_q <= '0;
      end else if (clr) begin
         acc_q <= '0;
         cnt_q <= '0;
      end else begin
         acc_q <= acc_n;
         cnt_q <= cnt_n;
      end
   end
endmodule

// File: rtl/tdc_frame_packer.sv
module tdc_frame_packer
   import tfp_pkg::*;
#(
   parameter int NCH      = 32,
   parameter int DT_W     = 6,
   parameter int MAX_BX   = 3,
   parameter int HDR_W    = 32,
   parameter int SLOT_CYC = 36,
   parameter int ACC_W    = 24
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [$clog2(MAX_BX+1)-1:0]          cfg_bx,
   input  logic                                 trig_valid,
   input  logic [HDR_W-1:0]                     trig_hdr,
   input  logic [NCH*MAX_BX-1:0]                trig_masks,
   input  logic [NCH*MAX_BX*DT_W-1:0]           trig_times,
   output logic                                 out_valid,
   output logic [7:0]                           out_data,
   output logic                                 out_last,
   output logic                                 spacing_err
);
   localparam int NTOT       = NCH * MAX_BX;
   localparam int CFG_W      = $clog2(MAX_BX + 1);
   localparam int HDR_BYTES  = HDR_W / BYTE_W;
   localparam int MASK_BYTES = NCH / BYTE_W;
   localparam int BIDX_W     = $clog2(SLOT_CYC + 1);
   localparam int CNT_W      = $clog2(ACC_W + 1);

   if (HDR_W % BYTE_W != 0) begin : g_bad_hdr
      $error("header width must be a whole number of bytes");
   end
   if (NCH % BYTE_W != 0) begin : g_bad_nch
      $error("channel count must be a multiple of the byte width");
   end
   if (DT_W > BYTE_W || ACC_W < BYTE_W + 2*DT_W) begin : g_bad_acc
      $error("packer accumulator too narrow to sustain one byte per cycle");
   end
   if (SLOT_CYC < HDR_BYTES + MASK_BYTES*MAX_BX) begin : g_bad_slot
      $error("slot too short for header and all hit masks");
   end

   // crossing count with zero and overrange folded into 1..MAX_BX
   logic [CFG_W-1:0] nbx_in;
   if (MAX_BX == 1) begin : g_bx_fixed
      assign nbx_in = CFG_W'(1);
   end else begin : g_bx_cfg
      assign nbx_in = (cfg_bx == '0)                ? CFG_W'(1) :
                      (cfg_bx > CFG_W'(MAX_BX))    ? CFG_W'(MAX_BX) : cfg_bx;
   end

   logic [NTOT-1:0] mask_ld;
   for (genvar b = 0; b < MAX_BX; b++) begin : g_mask_gate
      assign mask_ld[b*NCH +: NCH] = (nbx_in > CFG_W'(b)) ? trig_masks[b*NCH +: NCH] : '0;
   end

   logic accept;
   tfp_slot_timer #(.SLOT_CYC(SLOT_CYC)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig      (trig_valid),
      .accept    (accept),
      .viol_flag (spacing_err)
   );

   logic              active_q;
   logic [BIDX_W-1:0] idx_q;
   logic [CFG_W-1:0]  nbx_q;
   logic [HDR_W-1:0]  hdr_q;
   logic [NTOT-1:0]   mask_q;

   logic [1:0]        take, avail;
   logic [DT_W-1:0]   d1, d2;
   logic              scan_empty;
   logic [BYTE_W-1:0] pk_byte;
   logic [CNT_W-1:0]  pk_cnt;
   logic              emit;
   seg_e              seg;
   logic [BIDX_W-1:0] drift_start;

   assign drift_start = BIDX_W'(HDR_BYTES) + BIDX_W'(MASK_BYTES) * BIDX_W'(nbx_q);

   always_comb begin
      if (idx_q < BIDX_W'(HDR_BYTES))
         seg = SEG_HDR;
      else if (idx_q < drift_start)
         seg = SEG_MASK;
      else
         seg = SEG_DRIFT;
   end

   assign emit = active_q && (seg == SEG_DRIFT);

   tfp_hit_scan #(.NTOT(NTOT), .DT_W(DT_W)) u_scan (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (accept),
      .load_mask  (mask_ld),
      .load_times (trig_times),
      .take       (take),
      .d1         (d1),
      .d2         (d2),
      .avail      (avail),
      .empty      (scan_empty)
   );

   tfp_bit_packer #(.DT_W(DT_W), .ACC_W(ACC_W)) u_pack (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (accept),
      .en     (active_q),
      .emit   (emit),
      .avail  (avail),
      .d1     (d1),
      .d2     (d2),
      .take   (take),
      .byte_o (pk_byte),
      .cnt_o  (pk_cnt)
   );

   // byte selection for the current frame position
   always_comb begin
      int hb;
      int mb;
      hb = int'(idx_q) % HDR_BYTES;
      mb = (int'(idx_q) - HDR_BYTES) % (MASK_BYTES * MAX_BX);
      if (mb < 0)
         mb = 0;
      case (seg)
         SEG_HDR:  out_data = hdr_q[hb*BYTE_W +: BYTE_W];
         SEG_MASK: out_data = mask_q[mb*BYTE_W +: BYTE_W];
         default:  out_data = pk_byte;
      endcase
   end

   logic last_budget, last_nohit, last_drift;
   assign last_budget = (idx_q == BIDX_W'(SLOT_CYC - 1));
   assign last_nohit  = (seg == SEG_MASK) && (idx_q == drift_start - 1'b1) &&
                        scan_empty && (pk_cnt == '0);
   assign last_drift  = (seg == SEG_DRIFT) && scan_empty && (pk_cnt <= CNT_W'(BYTE_W));

   assign out_valid = active_q;
   assign out_last  = active_q && (last_budget || last_nohit || last_drift);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         idx_q    <= '0;
         nbx_q    <= CFG_W'(1);
         hdr_q    <= '0;
         mask_q   <= '0;
      end else if (accept) begin
         active_q <= 1'b1;
         idx_q    <= '0;
         nbx_q    <= nbx_in;
         hdr_q    <= trig_hdr;
         mask_q   <= mask_ld;
      end else if (out_last) begin
         active_q <= 1'b0;
         idx_q    <= '0;
      end else if (active_q) begin
         idx_q    <= idx_q + 1'b1;
      end
   end
endmodule

// File: rtl/tfp_frame_checker.sv
module tfp_frame_checker #(
   parameter int SLOT_CYC = 36
) (
   input logic clk,
   input logic rst_n,
   input logic trig_valid,
   input logic out_valid,
   input logic out_last,
   input logic spacing_err
);
   localparam int BW = $clog2(SLOT_CYC + 1);

   logic [BW-1:0] sent_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sent_q <= '0;
      else if (!out_valid || out_last)
         sent_q <= '0;
      else
         sent_q <= sent_q + 1'b1;
   end

   // R4: frame length bounded by the slot
   a_r4_budget: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (sent_q < BW'(SLOT_CYC)));

   // R4: the byte at the slot boundary is always the last one
   a_r4_cut: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && sent_q == BW'(SLOT_CYC - 1)) |-> out_last);

   // R6: no gap inside a frame
   a_r6_contig: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_last) |=> out_valid);

   // R6: last only with valid
   a_r6_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);

   // R1: a frame starts only right after a trigger
   a_r1_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(trig_valid));

   // R7: violation flag is sticky and caused by a trigger
   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      spacing_err |=> spacing_err);

   a_r7_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spacing_err) |-> $past(trig_valid));
endmodule

bind tdc_frame_packer tfp_frame_checker #(.SLOT_CYC(SLOT_CYC)) u_frame_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .trig_valid  (trig_valid),
   .out_valid   (out_valid),
   .out_last    (out_last),
   .spacing_err (spacing_err)
);

// File: tb/tdc_frame_packer_bench.sv
module tdc_frame_packer_bench;
   localparam int NTOT = 96;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [1:0]     cfg_bx = 2'd1;
   logic           trig_valid = 1'b0;
   logic [31:0]    trig_hdr = '0;
   logic [95:0]    trig_masks = '0;
   logic [575:0]   trig_times = '0;
   logic           out_valid, out_last, spacing_err;
   logic [7:0]     out_data;

   int n_cmp = 0;
   int n_bad = 0;

   logic [7:0] q_d[$];
   logic       q_l[$];
   string      q_t[$];

   always #2 clk = ~clk;

   tdc_frame_packer u_tdc_frame_packer (
      .clk(clk), .rst_n(rst_n), .cfg_bx(cfg_bx), .trig_valid(trig_valid),
      .trig_hdr(trig_hdr), .trig_masks(trig_masks), .trig_times(trig_times),
      .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
      .spacing_err(spacing_err)
   );

   task automatic chk(input bit ok, input string tag, input int got, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s got %0h expected %0h", tag, got, exp);
      end
   endtask

   function automatic logic [575:0] mk_times(input int seed);
      logic [575:0] t;
      for (int i = 0; i < NTOT; i++)
         t[i*6 +: 6] = 6'((i*13 + seed) % 64);
      return t;
   endfunction

   // expected frame from the requirements, pushed to the scoreboard
   task automatic expect_frame(input logic [31:0] h, input logic [1:0] cfg,
                               input logic [95:0] m, input logic [575:0] t, input string tag);
      int n;
      logic [7:0] fr[$];
      bit sb[$];
      n = (cfg == 2'd0) ? 1 : int'(cfg);
      for (int k = 0; k < 4; k++) fr.push_back(h[k*8 +: 8]);          // R1
      for (int k = 0; k < 4*n; k++) fr.push_back(m[k*8 +: 8]);        // R2, R5
      for (int g = 0; g < 32*n; g++)                                   // R3
         if (m[g])
            for (int b = 0; b < 6; b++) sb.push_back(t[g*6 + b]);
      while (sb.size() % 8 != 0) sb.push_back(1'b0);
      for (int k = 0; k < sb.size()/8; k++) begin
         logic [7:0] by;
         for (int b = 0; b < 8; b++) by[b] = sb[k*8 + b];
         fr.push_back(by);
      end
      while (fr.size() > 36) void'(fr.pop_back());                     // R4
      for (int k = 0; k < fr.size(); k++) begin
         q_d.push_back(fr[k]);
         q_l.push_back(k == fr.size() - 1);                            // R6, R8
         q_t.push_back(tag);
      end
   endtask

   // call at a falling edge; trigger seen at the next rising edge
   task automatic pulse(input logic [31:0] h, input logic [1:0] cfg,
                        input logic [95:0] m, input logic [575:0] t);
      trig_hdr = h; cfg_bx = cfg; trig_masks = m; trig_times = t;
      trig_valid = 1'b1;
      @(negedge clk);
      trig_valid = 1'b0;
      trig_masks = ~trig_masks;
      trig_hdr = ~trig_hdr;
   endtask

   task automatic send(input logic [31:0] h, input logic [1:0] cfg,
                       input logic [95:0] m, input logic [575:0] t, input string tag);
      expect_frame(h, cfg, m, t, tag);
      pulse(h, cfg, m, t);
   endtask

   // monitor: compare each byte as it appears
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (q_d.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R7 unexpected byte got %0h expected none", out_data);
         end else begin
            logic [7:0] ed; logic el; string et;
            ed = q_d.pop_front(); el = q_l.pop_front(); et = q_t.pop_front();
            chk(out_data == ed, {et, " data"}, int'(out_data), int'(ed));
            chk(out_last == el, {et, " R6 last"}, int'(out_last), int'(el));
         end
      end
   end

   initial begin
      #(4*150000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R9 valid after reset", int'(out_valid), 0);
      chk(spacing_err == 1'b0, "R9 flag after reset", int'(spacing_err), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R8, R2: single crossing, no hits
      send(32'hA1B2C3D4, 2'd1, 96'h0, mk_times(1), "R8 R2 nohit");
      repeat (40) @(negedge clk);

      // R3: sparse hits with padding
      send(32'h01020304, 2'd1, {64'hFFFF_FFFF_FFFF_FFFF, 32'h8000_0021}, mk_times(5), "R3 sparse");
      repeat (40) @(negedge clk);

      // R2, R3: two crossings, third crossing mask ignored, exact byte fill
      send(32'hCAFE0001, 2'd2, {32'h1234_5678, 32'h8000_0001, 32'h0000_0003}, mk_times(9), "R2 R3 two bx");
      repeat (40) @(negedge clk);

      // R2: configuration 0 behaves as one crossing
      send(32'h0BAD0BAD, 2'd0, {32'h0, 32'hFFFF_0000, 32'h0000_0110}, mk_times(17), "R2 cfg zero");
      repeat (40) @(negedge clk);

      // R3, R4: all 32 hits of one crossing fit in 32 bytes
      send(32'h11223344, 2'd1, {64'h0, 32'hFFFF_FFFF}, mk_times(23), "R3 R4 full fit");
      repeat (40) @(negedge clk);

      // R2, R3: hits only in the third crossing
      send(32'h55AA55AA, 2'd3, {32'h0001_8004, 64'h0}, mk_times(31), "R2 R3 third bx");
      repeat (40) @(negedge clk);
      chk(spacing_err == 1'b0, "R7 no flag on spaced triggers", int'(spacing_err), 0);

      // R4, R5: three crossings fully hit, truncated at 36 bytes
      send(32'hDEADBEEF, 2'd3, {96{1'b1}}, mk_times(2), "R4 R5 trunc");
      repeat (9) @(negedge clk);
      // R7: too early, ignored
      pulse(32'h77777777, 2'd1, {96{1'b1}}, mk_times(40));
      chk(spacing_err == 1'b1, "R7 flag on early trigger", int'(spacing_err), 1);
      repeat (25) @(negedge clk);
      // R7, R6: exactly one slot later, back to back
      send(32'h89ABCDEF, 2'd2, {32'h0, 32'h0000_00FF, 32'hFFFF_FFFF}, mk_times(7), "R7 R4 back to back");
      repeat (60) @(negedge clk);

      chk(q_d.size() == 0, "R6 all bytes seen", q_d.size(), 0);
      chk(spacing_err == 1'b1, "R7 flag sticky", int'(spacing_err), 1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule